// File: doc/BRIEF.md
# I2C Bus Watchdog with Hung-Bus Recovery

This block watches the SCL and SDA lines of an I2C bus for a period of silence, which typically follows a transfer that ended abnormally. It counts silence in units of an external 50 ns tick strobe. When the silence lasts long enough, the block looks at SDA. If SDA is high, the bus is reported as free. If SDA is low, a target device is assumed to be stuck mid-byte. The block then takes over SCL through an open-drain pull-down and clocks out up to nine pulses, so that the stuck device can finish shifting and release SDA.

One control input chooses between a short silence window and a long one. A second control input switches the whole watchdog off. Both windows, the pulse phase length and the pulse count are parameters, so a simulation can use small values. Normal master transfers are handled elsewhere. This block only watches the lines and performs the clearing sequence. The SCL and SDA inputs are expected to be already synchronised to `clk`.

Top module: `i2c_bus_guard`

## Requirements
- R1: After a synchronous reset, `bus_free`, `rcv_active` and `scl_pull` are all 0.
- R2: With `fast_to`=1, SDA high and no line activity, `bus_free` rises after SHORT_TICKS ticks of silence.
- R3: With `fast_to`=0, the silence window is LONG_TICKS ticks. A silence of SHORT_TICKS ticks does not set `bus_free` in this mode.
- R4: If the window expires while SDA is high, `bus_free` is set to 1 and no recovery is started.
- R5: If the window expires while SDA is low, `rcv_active` rises and the block emits up to PULSES clock pulses. For each pulse, `scl_pull`=1 (drive SCL low) is held for PULSE_TICKS ticks, and then `scl_pull`=0 (SCL released) is held for PULSE_TICKS ticks.
- R6: Any level change on SCL or SDA outside recovery restarts the silence count from zero.
- R7: If SDA is high at the end of a pulse's released phase, recovery stops after that pulse, before the full count is reached.
- R8: Any level change on SCL or SDA outside recovery clears `bus_free` on the next clock.
- R9: When recovery ends, `rcv_active` falls and the silence count restarts from zero. Line changes during recovery, including the block's own pulses, do not count as activity.
- R10: While `wd_off`=1, the count is held at zero, any recovery in progress is abandoned, and `bus_free`, `rcv_active` and `scl_pull` are all 0 from the next clock.
- R11: The silence count advances only on clock cycles where `tick`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Synchronised SCL line level |
| sda_in | input | 1 | Synchronised SDA line level |
| tick | input | 1 | One-cycle strobe every 50 ns |
| fast_to | input | 1 | 1 selects the short silence window, 0 the long one |
| wd_off | input | 1 | 1 disables the watchdog |
| bus_free | output | 1 | Bus judged free after silence with SDA high |
| rcv_active | output | 1 | Hung-bus recovery in progress |
| scl_pull | output | 1 | Open-drain enable: 1 drives SCL low |

## Verification
A silence counter that is off by a few ticks, or that ignores `tick`, shows up as `bus_free` or `rcv_active` rising outside a narrow window around the nominal expiry. That error is visible within one window length of the last line edge. A pulse sequencer in a wrong state shows up as a wrong number of `scl_pull` pulses, or a wrong pulse width, within the same recovery episode. The scoreboard compares each episode's pulse count when `rcv_active` falls. A missed abort or a missed activity clear appears on the outputs one clock after `wd_off` or the line edge.

// File: rtl/i2cg_pkg.sv
package i2cg_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LOW  = 2'd1,
    SEQ_REL  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/i2cg_edge.sv
module i2cg_edge (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic act
);
  logic scl_q, sda_q;

  // Idle I2C lines sit high, so the history registers reset high.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
    end
  end

  assign act = (scl_in ^ scl_q) | (sda_in ^ sda_q);
endmodule

// File: rtl/i2cg_idle_timer.sv
module i2cg_idle_timer #(
  parameter int SHORT_TICKS = 1000,
  parameter int LONG_TICKS  = 20000000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic fast_to,
  input  logic clear,
  output logic expire
);
  localparam int MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last   = fast_to ? SHORT_LAST : LONG_LAST;
  // ">=" covers a switch from the long window to the short one mid-count.
  assign expire = tick & ~clear & (cnt >= last);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt >= last) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  // R11: the count only moves on tick cycles.
  a_r11_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clear) |=> $stable(cnt));
endmodule

// File: rtl/i2cg_clr_seq.sv
module i2cg_clr_seq
  import i2cg_pkg::*;
#(
  parameter int PULSE_TICKS = 100,
  parameter int PULSES      = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start,
  input  logic abort,
  input  logic sda_in,
  output logic busy,
  output logic pull
);
  localparam int PW = $clog2(PULSE_TICKS + 1);
  localparam int NW = $clog2(PULSES + 1);
  localparam logic [PW-1:0] PH_LAST = PW'(PULSE_TICKS - 1);
  localparam logic [NW-1:0] N_LAST  = NW'(PULSES - 1);

  seq_state_t    st;
  logic [PW-1:0] ph;
  logic [NW-1:0] pc;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      st   <= SEQ_IDLE;
      ph   <= '0;
      pc   <= '0;
      pull <= 1'b0;
      busy <= 1'b0;
    end else begin
      case (st)
        SEQ_IDLE: if (start) begin
          st   <= SEQ_LOW;
          ph   <= '0;
          pc   <= '0;
          pull <= 1'b1;
          busy <= 1'b1;
        end
        SEQ_LOW: if (tick) begin
          if (ph == PH_LAST) begin
            ph   <= '0;
            pull <= 1'b0;
            st   <= SEQ_REL;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        SEQ_REL: if (tick) begin
          if (ph == PH_LAST) begin
            ph <= '0;
            pc <= pc + 1'b1;
            if (sda_in || pc == N_LAST) begin
              st   <= SEQ_IDLE;
              busy <= 1'b0;
            end else begin
              st   <= SEQ_LOW;
              pull <= 1'b1;
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  // R5: never more pulses than configured.
  a_r5_pulse_cap: assert property (@(posedge clk) disable iff (rst)
    pc <= NW'(PULSES));
  // R7: SDA high at the end of a released phase ends the episode.
  a_r7_sda_stop: assert property (@(posedge clk) disable iff (rst || abort)
    (st == SEQ_REL && tick && ph == PH_LAST && sda_in) |=> !busy);
endmodule

// File: rtl/i2c_bus_guard.sv
module i2c_bus_guard #(
  parameter int SHORT_TICKS = 1000,
  parameter int LONG_TICKS  = 20000000,
  parameter int PULSE_TICKS = 100,
  parameter int PULSES      = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  input  logic tick,
  input  logic fast_to,
  input  logic wd_off,
  output logic bus_free,
  output logic rcv_active,
  output logic scl_pull
);
  logic act, expire, tmr_clear, start;

  i2cg_edge u_edge (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .act(act)
  );

  // Recovery holds the count at zero, so its own SCL edges are ignored.
  assign tmr_clear = act | rcv_active | wd_off;

  i2cg_idle_timer #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) u_tmr (
    .clk(clk), .rst(rst), .tick(tick), .fast_to(fast_to),
    .clear(tmr_clear), .expire(expire)
  );

  assign start = expire & ~sda_in;

  i2cg_clr_seq #(.PULSE_TICKS(PULSE_TICKS), .PULSES(PULSES)) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .start(start), .abort(wd_off),
    .sda_in(sda_in), .busy(rcv_active), .pull(scl_pull)
  );

  always_ff @(posedge clk) begin
    if (rst || wd_off)             bus_free <= 1'b0;
    else if (act && !rcv_active)   bus_free <= 1'b0;
    else if (expire && sda_in)     bus_free <= 1'b1;
  end

  // R4: a free bus and a recovery never coexist.
  a_r4_free_excl: assert property (@(posedge clk) disable iff (rst)
    !(bus_free && rcv_active));
  // R8: line activity outside recovery clears the free flag.
  a_r8_act_clears: assert property (@(posedge clk) disable iff (rst)
    (act && !rcv_active) |=> !bus_free);
  // R10: disable silences every output on the next clock.
  a_r10_off_quiet: assert property (@(posedge clk) disable iff (rst)
    wd_off |=> (!bus_free && !rcv_active && !scl_pull));
endmodule

// File: tb/tb_i2c_bus_guard.sv
module tb_i2c_bus_guard;
  localparam int SHORT = 20;
  localparam int LONG  = 80;
  localparam int PT    = 3;
  localparam int NP    = 9;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic tick, fast_to = 1'b1, wd_off = 1'b0;
  logic bus_free, rcv_active, scl_pull;
  logic scl_in;
  int   tick_div = 1, tdc = 0;
  int   errors = 0, checks = 0, cycles = 0;
  int   exp_q[$];
  int   ep_pulses = 0, low_len = 0;
  logic prev_pull = 1'b0, prev_busy = 1'b0;

  always #2 clk = ~clk;

  // Open-drain wire: the bench's own driver ANDed with the block's pull-down.
  assign scl_in = scl_drv & ~scl_pull;
  assign tick   = (tdc == 0);

  i2c_bus_guard #(.SHORT_TICKS(SHORT), .LONG_TICKS(LONG),
                  .PULSE_TICKS(PT), .PULSES(NP)) dut (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_drv), .tick(tick),
    .fast_to(fast_to), .wd_off(wd_off), .bus_free(bus_free),
    .rcv_active(rcv_active), .scl_pull(scl_pull)
  );

  always @(negedge clk) tdc <= (tdc + 1 >= tick_div) ? 0 : tdc + 1;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic kick();
    scl_drv = 1'b0; step(1);
    scl_drv = 1'b1; step(1);
  endtask

  task automatic wait_busy(input logic v, input int maxc);
    for (int i = 0; i < maxc && rcv_active !== v; i++) @(negedge clk);
  endtask

  // Scoreboard monitor: pulse count and low-phase width per recovery episode.
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      if (scl_pull && !prev_pull) ep_pulses++;
      if (scl_pull) low_len++;
      if (!scl_pull && prev_pull) begin
        if (!wd_off) begin
          checks++;
          if (low_len != PT * tick_div) begin
            errors++;
            $display("FAIL R5: low phase %0d cycles expected %0d", low_len, PT * tick_div);
          end
        end
        low_len = 0;
      end
      if (prev_busy && !rcv_active) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R5: unexpected episode with %0d pulses expected none", ep_pulses);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (e != ep_pulses) begin
            errors++;
            $display("FAIL R5/R7: episode pulses %0d expected %0d", ep_pulses, e);
          end
        end
        ep_pulses = 0;
      end
    end
    prev_pull = scl_pull;
    prev_busy = rcv_active;
  end

  initial begin
    step(200000);
    errors++; checks++;
    $display("FAIL watchdog: run hung got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    chk("R1 bus_free", bus_free, 1'b0);
    chk("R1 rcv_active", rcv_active, 1'b0);
    chk("R1 scl_pull", scl_pull, 1'b0);

    // R2/R4: short window, SDA high
    kick();
    step(SHORT - 2); chk("R2 early", bus_free, 1'b0);
    step(4);         chk("R2 expiry", bus_free, 1'b1);
    chk("R4 no recovery", rcv_active, 1'b0);

    // R8: activity clears free
    sda_drv = 1'b0; step(2);
    chk("R8 clear", bus_free, 1'b0);
    sda_drv = 1'b1; step(1);

    // R3: long window
    fast_to = 1'b0; kick();
    step(SHORT + 5); chk("R3 not at short", bus_free, 1'b0);
    step(LONG - SHORT - 7); chk("R3 early", bus_free, 1'b0);
    step(4); chk("R3 expiry", bus_free, 1'b1);
    fast_to = 1'b1; kick();

    // R6: periodic activity keeps restarting the count
    begin
      logic seen = 1'b0;
      for (int k = 0; k < 8; k++) begin
        scl_drv = ~scl_drv;
        for (int j = 0; j < 12; j++) begin @(negedge clk); if (bus_free) seen = 1'b1; end
      end
      chk("R6 restart", seen, 1'b0);
    end
    scl_drv = 1'b1; step(1);

    // R5 full nine pulses with SDA stuck low
    exp_q.push_back(NP);
    sda_drv = 1'b0; step(1);
    step(SHORT + 3); chk("R5 start", rcv_active, 1'b1);
    chk("R5 not free", bus_free, 1'b0);
    wait_busy(1'b0, 2 * PT * NP + 20);
    chk("R5 ended", rcv_active, 1'b0);

    // R9 restart, then R7 early stop after pulse 3
    exp_q.push_back(3);
    step(SHORT - 2); chk("R9 restart early", rcv_active, 1'b0);
    step(4);         chk("R9 restart expiry", rcv_active, 1'b1);
    for (int i = 0; i < 200 && ep_pulses < 3; i++) @(negedge clk);
    sda_drv = 1'b1;
    wait_busy(1'b0, 4 * PT + 10);
    chk("R7 stopped", rcv_active, 1'b0);
    chk("R7 released", scl_pull, 1'b0);
    step(SHORT - 2); chk("R9 free early", bus_free, 1'b0);
    step(4);         chk("R9 free after", bus_free, 1'b1);

    // R10: disable
    wd_off = 1'b1; step(2);
    chk("R10 free cleared", bus_free, 1'b0);
    step(3 * SHORT); chk("R10 no expiry", bus_free, 1'b0);
    sda_drv = 1'b0; step(3 * SHORT);
    chk("R10 no recovery", rcv_active, 1'b0);
    wd_off = 1'b0;
    exp_q.push_back(2);
    wait_busy(1'b1, SHORT + 10);
    for (int i = 0; i < 200 && ep_pulses < 2; i++) @(negedge clk);
    step(1);
    wd_off = 1'b1; step(2);
    chk("R10 abort busy", rcv_active, 1'b0);
    chk("R10 abort pull", scl_pull, 1'b0);
    sda_drv = 1'b1; step(2);
    wd_off = 1'b0; step(1);

    // R11: one tick every 4 cycles
    tick_div = 4; kick();
    step(4 * SHORT - 6); chk("R11 early", bus_free, 1'b0);
    step(8);             chk("R11 expiry", bus_free, 1'b1);

    step(5);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R5: %0d episodes missing expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule